// File: doc/BRIEF.md
# Transmit Packet Size Checker

This block watches the words pushed into a transmit FIFO and checks each packet's length. It counts the data words accepted for the packet that is currently open. When software writes the packet length in bytes, the block works out how many bus words that byte length occupies and compares that figure with the count. If the two differ, it raises a one-cycle size-error pulse. If they agree, it raises a one-cycle transmit-complete pulse. Either way, the word count then starts again from zero for the next packet.

A word write that arrives while the FIFO reports full is an overrun. The block emits a one-cycle overrun pulse and enters a lockout state. In lockout, word writes and length writes are ignored and no events are produced. Only the synchronous transmit reset input leaves the lockout. The FIFO storage is outside this block. The bus word is 4 or 8 bytes wide, chosen by parameter, and the byte length field is 23 bits.

Top module: `tx_size_checker`

## Requirements
- R1: After the asynchronous reset `rst_ni`, every output is 0 and the word count is 0.
- R2: The expected word count is ceil(length / WORD_BYTES), with WORD_BYTES = 4 by default. On a length write whose expected count equals the words accepted, `done_o` pulses high for exactly one cycle, in the cycle after the write. `size_err_o` stays low in that case.
- R3: On a length write whose expected word count differs from the words accepted, `size_err_o` pulses high for exactly one cycle, in the cycle after the write. `done_o` stays low in that case.
- R4: Byte lengths that differ only inside the last word give the same result. With 4-byte words, lengths 9 to 12 all match 3 written words.
- R5: The word count returns to 0 after every accepted length write, whether it matched or not.
- R6: A word write with `fifo_full_i` high outside lockout pulses `overrun_o` for one cycle, in the cycle after the write. `lock_o` goes high in that same cycle and stays high until a transmit reset.
- R7: While `lock_o` is high, word writes and length writes produce no `size_err_o`, `done_o` or `overrun_o` pulse, and they are not counted.
- R8: `tx_reset_i` clears the lockout and the word count, and it overrides every other input in its cycle.
- R9: A word write accepted in the same cycle as a length write counts toward the packet being closed.
- R10: A full-FIFO write is not counted. A length write in the same cycle as the overrun is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_reset_i | input | 1 | Synchronous transmit reset; clears count and lockout |
| wr_word_i | input | 1 | One data word is written to the transmit FIFO |
| fifo_full_i | input | 1 | Transmit FIFO is full |
| len_wr_i | input | 1 | Software writes the packet byte length |
| len_bytes_i | input | 23 | Packet length in bytes |
| size_err_o | output | 1 | One-cycle pulse: word count mismatch |
| done_o | output | 1 | One-cycle pulse: packet closed without size error |
| overrun_o | output | 1 | One-cycle pulse: write attempted while full |
| lock_o | output | 1 | Overrun lockout active |

## Verification
Two functions can fall in the same cycle: the last word write of a packet and the length write that closes it. The bench drives both in one cycle and expects the length check to include that word. A second collision is an overrun write together with a length write. Here the bench expects only the overrun pulse, with no completion or size error. A transmit reset is also issued on the same cycle as a word write, and the next packet is judged on a count that starts from zero.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_LOCK = 1'b1} tsc_state_e;
endpackage

// File: rtl/tsc_len_words.sv
// Byte length -> whole words, rounded up.
module tsc_len_words #(
  parameter int WORD_BYTES = 4,
  parameter int LEN_W      = 23,
  parameter int EXP_W      = 22
) (
  input  logic [LEN_W-1:0] len_bytes_i,
  output logic [EXP_W-1:0] words_o
);
  localparam int SHIFT = $clog2(WORD_BYTES);

  logic [LEN_W-1:0] whole;
  logic             part;

  generate
    if (WORD_BYTES == 8) begin : g_w8
      assign whole = len_bytes_i >> 3;
      assign part  = |len_bytes_i[2:0];
    end else begin : g_w4
      assign whole = len_bytes_i >> 2;
      assign part  = |len_bytes_i[1:0];
    end
  endgenerate

  assign words_o = EXP_W'(whole) + EXP_W'(part);

  logic unused_shift;
  assign unused_shift = (SHIFT == 0);
endmodule

// File: rtl/tsc_word_cnt.sv
// Saturating per-packet word counter; clear wins.
module tsc_word_cnt #(
  parameter int CNT_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_next_o = cnt_q;
    if (inc_i && cnt_q != CNT_MAX) cnt_next_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_next_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tsc_ctrl.sv
// Lockout state and registered event outputs.
module tsc_ctrl
  import tsc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_reset_i,
  input  logic ovr_hit_i,
  input  logic len_ok_i,
  input  logic mismatch_i,
  output logic run_o,
  output logic size_err_o,
  output logic done_o,
  output logic overrun_o,
  output logic lock_o
);
  tsc_state_e state_q, state_d;
  logic se_q, dn_q, ov_q;

  always_comb begin
    state_d = state_q;
    if (tx_reset_i)     state_d = ST_RUN;
    else if (ovr_hit_i) state_d = ST_LOCK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      se_q    <= 1'b0;
      dn_q    <= 1'b0;
      ov_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      se_q    <= len_ok_i & mismatch_i;
      dn_q    <= len_ok_i & ~mismatch_i;
      ov_q    <= ovr_hit_i;
    end
  end

  assign run_o      = (state_q == ST_RUN);
  assign size_err_o = se_q;
  assign done_o     = dn_q;
  assign overrun_o  = ov_q;
  assign lock_o     = (state_q == ST_LOCK);
endmodule

// File: rtl/tx_size_checker.sv
module tx_size_checker #(
  parameter int WORD_BYTES = 4,
  parameter int LEN_W      = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_reset_i,
  input  logic             wr_word_i,
  input  logic             fifo_full_i,
  input  logic             len_wr_i,
  input  logic [LEN_W-1:0] len_bytes_i,
  output logic             size_err_o,
  output logic             done_o,
  output logic             overrun_o,
  output logic             lock_o
);
  localparam int SHIFT = $clog2(WORD_BYTES);
  localparam int EXP_W = LEN_W - SHIFT + 1;

  logic             run;
  logic             live;
  logic             word_ok, ovr_hit, len_ok, mismatch;
  logic [EXP_W-1:0] exp_words, cnt, cnt_next;

  // Active cycle: not locked and no transmit reset pending.
  assign live     = run & ~tx_reset_i;
  assign ovr_hit  = live & wr_word_i & fifo_full_i;
  assign word_ok  = live & wr_word_i & ~fifo_full_i;
  assign len_ok   = live & len_wr_i & ~ovr_hit;
  assign mismatch = (cnt_next != exp_words);

  tsc_len_words #(
    .WORD_BYTES (WORD_BYTES),
    .LEN_W      (LEN_W),
    .EXP_W      (EXP_W)
  ) u_len (
    .len_bytes_i (len_bytes_i),
    .words_o     (exp_words)
  );

  tsc_word_cnt #(
    .CNT_W (EXP_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (tx_reset_i | len_ok),
    .inc_i      (word_ok),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next)
  );

  tsc_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_reset_i (tx_reset_i),
    .ovr_hit_i  (ovr_hit),
    .len_ok_i   (len_ok),
    .mismatch_i (mismatch),
    .run_o      (run),
    .size_err_o (size_err_o),
    .done_o     (done_o),
    .overrun_o  (overrun_o),
    .lock_o     (lock_o)
  );

  logic unused_cnt;
  assign unused_cnt = ^cnt;
endmodule

// File: rtl/tx_size_checker_sva.sv
module tx_size_checker_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_reset_i,
  input logic wr_word_i,
  input logic fifo_full_i,
  input logic len_wr_i,
  input logic size_err_o,
  input logic done_o,
  input logic overrun_o,
  input logic lock_o
);
  AST_ERR_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(size_err_o && done_o)); // R3
  AST_RESULT_NEEDS_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_err_o || done_o) |-> $past(len_wr_i)); // R2
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(wr_word_i && fifo_full_i)); // R6
  AST_OVR_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> lock_o); // R6
  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !tx_reset_i) |=> lock_o); // R6
  AST_LOCK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> (!size_err_o && !done_o && !overrun_o)); // R7
  AST_TXRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_reset_i |=> (!lock_o && !size_err_o && !done_o && !overrun_o)); // R8
endmodule

bind tx_size_checker tx_size_checker_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_reset_i  (tx_reset_i),
  .wr_word_i   (wr_word_i),
  .fifo_full_i (fifo_full_i),
  .len_wr_i    (len_wr_i),
  .size_err_o  (size_err_o),
  .done_o      (done_o),
  .overrun_o   (overrun_o),
  .lock_o      (lock_o)
);

// File: tb/tb_tx_size_checker.sv
`timescale 1ns/1ps
module tb_tx_size_checker;
  localparam int WB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txr = 1'b0, wr = 1'b0, full = 1'b0, lw = 1'b0;
  logic [22:0] len = '0;
  logic        se, dn, ov, lk;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  tx_size_checker #(.WORD_BYTES(WB), .LEN_W(23)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_reset_i(txr), .wr_word_i(wr),
    .fifo_full_i(full), .len_wr_i(lw), .len_bytes_i(len),
    .size_err_o(se), .done_o(dn), .overrun_o(ov), .lock_o(lk));

  // Behavioural reference model
  int m_cnt = 0;
  bit m_lock = 0, m_se = 0, m_dn = 0, m_ov = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_lock = 0; m_se = 0; m_dn = 0; m_ov = 0;
    end else begin
      m_se = 0; m_dn = 0; m_ov = 0;
      if (txr) begin
        m_cnt = 0; m_lock = 0;
      end else if (!m_lock) begin
        if (wr && full) begin
          m_ov = 1; m_lock = 1;
        end else begin
          int c;
          c = m_cnt + (wr ? 1 : 0);
          if (lw) begin
            int need;
            need = (int'(len) + WB - 1) / WB;
            if (c != need) m_se = 1; else m_dn = 1;
            m_cnt = 0;
          end else m_cnt = c;
        end
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      tests++;
      if (se !== m_se) begin fails++; $display("FAIL R3 size_err act=%b exp=%b t=%0t", se, m_se, $time); end
      tests++;
      if (dn !== m_dn) begin fails++; $display("FAIL R2 done act=%b exp=%b t=%0t", dn, m_dn, $time); end
      tests++;
      if (ov !== m_ov) begin fails++; $display("FAIL R6 overrun act=%b exp=%b t=%0t", ov, m_ov, $time); end
      tests++;
      if (lk !== m_lock) begin fails++; $display("FAIL R7 lock act=%b exp=%b t=%0t", lk, m_lock, $time); end
    end
  end

  task automatic step(input bit w, input bit f, input bit l, input int b, input bit r);
    wr = w; full = f; lw = l; len = 23'(b); txr = r;
    @(negedge clk);
    wr = 0; full = 0; lw = 0; txr = 0;
  endtask

  task automatic expect_out(input string req, input logic [3:0] exp);
    tests++;
    if ({se, dn, ov, lk} !== exp) begin
      fails++;
      $display("FAIL %s {se,dn,ov,lk} act=%b exp=%b t=%0t", req, {se, dn, ov, lk}, exp, $time);
    end
  endtask

  task automatic words(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1", 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1", 4'b0000);

    words(3); step(0, 0, 1, 12, 0); expect_out("R2", 4'b0100);
    @(negedge clk); expect_out("R2", 4'b0000); // one-cycle pulse
    words(3); step(0, 0, 1, 9, 0);  expect_out("R4", 4'b0100);
    words(3); step(0, 0, 1, 11, 0); expect_out("R4", 4'b0100);
    words(2); step(0, 0, 1, 12, 0); expect_out("R3", 4'b1000);
    @(negedge clk); expect_out("R3", 4'b0000);
    words(4); step(0, 0, 1, 12, 0); expect_out("R3", 4'b1000);
    step(0, 0, 1, 4, 0);            expect_out("R5", 4'b1000);
    words(1); step(0, 0, 1, 4, 0);  expect_out("R5", 4'b0100);
    step(0, 0, 1, 0, 0);            expect_out("R5", 4'b0100);
    words(2); step(1, 0, 1, 12, 0); expect_out("R9", 4'b0100);
    words(1); step(1, 0, 1, 5, 0);  expect_out("R9", 4'b0100);

    words(2); step(1, 1, 1, 8, 0);  expect_out("R10", 4'b0011);
    @(negedge clk); expect_out("R6", 4'b0001);
    words(3); step(0, 0, 1, 12, 0); expect_out("R7", 4'b0001);
    step(1, 1, 0, 0, 0);            expect_out("R7", 4'b0001);
    step(0, 0, 0, 0, 1);            expect_out("R8", 4'b0000);
    words(1); step(0, 0, 1, 3, 0);  expect_out("R8", 4'b0100);

    words(2); step(1, 0, 0, 0, 1);  expect_out("R8", 4'b0000);
    step(0, 0, 1, 0, 0);            expect_out("R8", 4'b0100);
    step(1, 1, 0, 0, 1);            expect_out("R8", 4'b0000);
    step(0, 0, 1, 0, 0);            expect_out("R10", 4'b0100);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule